// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order pipeline. It decides, separately for each of the two ALU operands, whether the value read from the register file is stale. An operand is stale when an older instruction that has not yet retired will write the same register. The instruction one stage ahead of execute sits in the execute/memory register. The instruction two stages ahead sits in the memory/writeback register. When either of them is about to write the register being read, the unit steers that pending result into the operand instead of the register-file value.

The unit is purely combinational. Each operand has two comparators, one per pending stage, so there are four in all. A priority encoder turns each operand's pair of comparator hits into a 2-bit select, and a three-way multiplexer uses that select to produce the operand. Register zero is hard-wired, so a pending write to it is never forwarded. When both stages hold a write to the same register, the younger result in the execute/memory stage wins. The memory/writeback path also gives write-through behaviour: a register that is written back in the same cycle it is read delivers the new value.

Top module: `operand_forward_unit`

## Requirements
- R1: The operand A select is 2'b10 and operand A equals the execute/memory result whenever the execute/memory stage has its write enable set, its destination id is non-zero, and that destination equals the source id of operand A.
- R2: Operand B uses the same rule against its own source id, independently of operand A, so the two selects may differ in the same cycle.
- R3: When the execute/memory stage does not match a source, but the memory/writeback stage has its write enable set, a non-zero destination, and a destination equal to that source, the select is 2'b01 and the operand equals the writeback value. This is the write-through case for a register read and written in the same cycle.
- R4: When both stages match the same source, the select is 2'b10 and the execute/memory result is used, because it is the younger result.
- R5: A pending write whose destination id is 0 never forwards in either stage, even when the source id is also 0. The select stays 2'b00 and the operand is the register-file value.
- R6: A stage whose write enable is clear never forwards, even when its destination equals the source.
- R7: With no qualifying match, the select is 2'b00 and the operand equals the register-file read value.
- R8: A select never takes the unused code 2'b11, and each operand always equals the source named by its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_id_i | input | 5 | Source register id of operand A for the instruction in execute |
| rt_id_i | input | 5 | Source register id of operand B for the instruction in execute |
| rs_rf_data_i | input | 32 | Register-file read value for operand A |
| rt_rf_data_i | input | 32 | Register-file read value for operand B |
| exmem_wen_i | input | 1 | Register-write enable held in the execute/memory register |
| exmem_dst_i | input | 5 | Destination register id held in the execute/memory register |
| exmem_res_i | input | 32 | ALU result held in the execute/memory register |
| memwb_wen_i | input | 1 | Register-write enable held in the memory/writeback register |
| memwb_dst_i | input | 5 | Destination register id held in the memory/writeback register |
| memwb_res_i | input | 32 | Writeback value held in the memory/writeback register |
| fwd_a_sel_o | output | 2 | Operand A source select: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b_sel_o | output | 2 | Operand B source select, same encoding |
| opnd_a_o | output | 32 | Selected operand A |
| opnd_b_o | output | 32 | Selected operand B |

## Verification
The bench drives both stages at the same destination as a source, with both write enables set. A design that ranked the older stage first would hand the ALU the writeback value, which is already superseded. It also drives register zero as source and destination with write enables asserted. A design missing the zero test would return a pending result where the hard-wired zero belongs. Cases where the two operands match different stages in the same cycle expose a select shared or swapped between operands. A randomised stream over a narrow id range makes id collisions frequent. That stream catches a dropped write-enable qualifier, which would forward results from instructions that never write.

// File: rtl/fwd_pkg.sv
// Shared definitions for the operand forwarding unit.
// Assumes a two-operand execute stage with two older pending stages.
package fwd_pkg;
    // Operand source codes; bit 1 names the younger stage, bit 0 the older one.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXRES   = 2'b10
    } fwd_src_e;

    // Number of ALU operands fed by the unit.
    localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
// One hazard comparator: flags that a pending stage will write the
// register an operand reads. Assumes register id 0 is hard-wired.
module fwd_match #(
    parameter int unsigned ID_W = 5
) (
    input  logic [ID_W-1:0] src_id_i,
    input  logic [ID_W-1:0] dst_id_i,
    input  logic            wen_i,
    output logic            hit_o
);
    localparam logic [ID_W-1:0] ZERO_REG = '0;

    logic dst_live;
    logic id_equal;

    // A write only counts if it is enabled and not aimed at the zero register.
    always_comb begin
        dst_live = wen_i && (dst_id_i != ZERO_REG);
        id_equal = (dst_id_i == src_id_i);
        hit_o    = dst_live && id_equal;
    end
endmodule

// File: rtl/fwd_pick.sv
// Priority encoder for one operand: the younger stage outranks the older.
// Assumes the two hits come from comparators against the same source id.
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     hit_young_i,
    input  logic     hit_old_i,
    output fwd_src_e sel_o
);
    // Choose the youngest pending producer, else the register file.
    always_comb begin
        if (hit_young_i)
            sel_o = SRC_EXRES;
        else if (hit_old_i)
            sel_o = SRC_WBACK;
        else
            sel_o = SRC_REGFILE;
    end
endmodule

// File: rtl/fwd_mux.sv
// Three-way operand multiplexer driven by a forwarding select.
// Assumes the unused select code never arrives; it maps to the register file.
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  fwd_src_e          sel_i,
    input  logic [DATA_W-1:0] rf_i,
    input  logic [DATA_W-1:0] exres_i,
    input  logic [DATA_W-1:0] wback_i,
    output logic [DATA_W-1:0] opnd_o
);
    // Route the chosen source onto the operand.
    always_comb begin
        case (sel_i)
            SRC_EXRES: opnd_o = exres_i;
            SRC_WBACK: opnd_o = wback_i;
            default:   opnd_o = rf_i;
        endcase
    end
endmodule

// File: rtl/operand_forward_unit.sv
// Operand forwarding unit for the execute stage of a five-stage pipeline.
// Compares both source ids against the destinations of the execute/memory
// and memory/writeback stages, and steers the freshest value into each
// operand. Purely combinational; it has no state and no reset.
module operand_forward_unit
    import fwd_pkg::*;
#(
    parameter int unsigned ID_W   = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ID_W-1:0]   rs_id_i,
    input  logic [ID_W-1:0]   rt_id_i,
    input  logic [DATA_W-1:0] rs_rf_data_i,
    input  logic [DATA_W-1:0] rt_rf_data_i,
    input  logic              exmem_wen_i,
    input  logic [ID_W-1:0]   exmem_dst_i,
    input  logic [DATA_W-1:0] exmem_res_i,
    input  logic              memwb_wen_i,
    input  logic [ID_W-1:0]   memwb_dst_i,
    input  logic [DATA_W-1:0] memwb_res_i,
    output logic [1:0]        fwd_a_sel_o,
    output logic [1:0]        fwd_b_sel_o,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o
);
    logic [NUM_OPND-1:0][ID_W-1:0]   src_ids;
    logic [NUM_OPND-1:0][DATA_W-1:0] rf_vals;
    logic [NUM_OPND-1:0][DATA_W-1:0] opnds;
    logic [NUM_OPND-1:0][1:0]        sels;

    // Gather per-operand inputs into indexable arrays.
    always_comb begin
        src_ids[0] = rs_id_i;
        src_ids[1] = rt_id_i;
        rf_vals[0] = rs_rf_data_i;
        rf_vals[1] = rt_rf_data_i;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic     hit_em;
        logic     hit_mw;
        fwd_src_e sel;

        fwd_match #(.ID_W(ID_W)) u_match_em (
            .src_id_i (src_ids[g]),
            .dst_id_i (exmem_dst_i),
            .wen_i    (exmem_wen_i),
            .hit_o    (hit_em)
        );

        fwd_match #(.ID_W(ID_W)) u_match_mw (
            .src_id_i (src_ids[g]),
            .dst_id_i (memwb_dst_i),
            .wen_i    (memwb_wen_i),
            .hit_o    (hit_mw)
        );

        fwd_pick u_pick (
            .hit_young_i (hit_em),
            .hit_old_i   (hit_mw),
            .sel_o       (sel)
        );

        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel_i   (sel),
            .rf_i    (rf_vals[g]),
            .exres_i (exmem_res_i),
            .wback_i (memwb_res_i),
            .opnd_o  (opnds[g])
        );

        assign sels[g] = sel;
    end

    // Present the per-operand results on the named ports.
    always_comb begin
        fwd_a_sel_o = sels[0];
        fwd_b_sel_o = sels[1];
        opnd_a_o    = opnds[0];
        opnd_b_o    = opnds[1];
    end
endmodule

// File: rtl/operand_forward_chk.sv
// Port-level checker for the forwarding unit; bound to every instance.
// Uses immediate assertions since the unit has no clock.
module operand_forward_chk #(
    parameter int unsigned ID_W   = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic [ID_W-1:0]   rs_id_i,
    input logic [ID_W-1:0]   rt_id_i,
    input logic [DATA_W-1:0] rs_rf_data_i,
    input logic [DATA_W-1:0] rt_rf_data_i,
    input logic              exmem_wen_i,
    input logic [ID_W-1:0]   exmem_dst_i,
    input logic [DATA_W-1:0] exmem_res_i,
    input logic              memwb_wen_i,
    input logic [ID_W-1:0]   memwb_dst_i,
    input logic [DATA_W-1:0] memwb_res_i,
    input logic [1:0]        fwd_a_sel_o,
    input logic [1:0]        fwd_b_sel_o,
    input logic [DATA_W-1:0] opnd_a_o,
    input logic [DATA_W-1:0] opnd_b_o
);
    // Check the port relations whenever any input or output changes.
    always_comb begin
        p_young_a_r1: assert (!(exmem_wen_i && exmem_dst_i != '0 && exmem_dst_i == rs_id_i)
                              || (fwd_a_sel_o == 2'b10 && opnd_a_o == exmem_res_i))
            else $error("operand A missed execute/memory forward");
        p_young_b_r2: assert (!(exmem_wen_i && exmem_dst_i != '0 && exmem_dst_i == rt_id_i)
                              || (fwd_b_sel_o == 2'b10 && opnd_b_o == exmem_res_i))
            else $error("operand B missed execute/memory forward");
        p_old_a_r3: assert (!(fwd_a_sel_o == 2'b01)
                            || (memwb_wen_i && memwb_dst_i != '0 && memwb_dst_i == rs_id_i))
            else $error("operand A writeback forward without a match");
        p_zero_a_r5: assert (!(rs_id_i == '0) || fwd_a_sel_o == 2'b00)
            else $error("operand A forwarded register zero");
        p_zero_b_r5: assert (!(rt_id_i == '0) || fwd_b_sel_o == 2'b00)
            else $error("operand B forwarded register zero");
        p_gate_r6: assert (exmem_wen_i || memwb_wen_i
                           || (fwd_a_sel_o == 2'b00 && fwd_b_sel_o == 2'b00))
            else $error("forward with both write enables clear");
        p_rf_a_r7: assert (fwd_a_sel_o != 2'b00 || opnd_a_o == rs_rf_data_i)
            else $error("operand A not the register-file value");
        p_code_r8: assert (fwd_a_sel_o != 2'b11 && fwd_b_sel_o != 2'b11)
            else $error("reserved select code");
        p_wb_b_r8: assert (fwd_b_sel_o != 2'b01 || opnd_b_o == memwb_res_i)
            else $error("operand B does not follow its select");
    end
endmodule

bind operand_forward_unit operand_forward_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
    .rs_id_i      (rs_id_i),
    .rt_id_i      (rt_id_i),
    .rs_rf_data_i (rs_rf_data_i),
    .rt_rf_data_i (rt_rf_data_i),
    .exmem_wen_i  (exmem_wen_i),
    .exmem_dst_i  (exmem_dst_i),
    .exmem_res_i  (exmem_res_i),
    .memwb_wen_i  (memwb_wen_i),
    .memwb_dst_i  (memwb_dst_i),
    .memwb_res_i  (memwb_res_i),
    .fwd_a_sel_o  (fwd_a_sel_o),
    .fwd_b_sel_o  (fwd_b_sel_o),
    .opnd_a_o     (opnd_a_o),
    .opnd_b_o     (opnd_b_o)
);

// File: tb/operand_forward_unit_tb.sv
// Bench for the forwarding unit: directed corner cases, then a random
// stream, each compared against a behavioural model on every clock.
module operand_forward_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;

    logic [4:0]  rs, rt, em_dst, mw_dst;
    logic        em_wen, mw_wen;
    logic [31:0] rs_rf, rt_rf, em_res, mw_res;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    operand_forward_unit u_dut (
        .rs_id_i      (rs),
        .rt_id_i      (rt),
        .rs_rf_data_i (rs_rf),
        .rt_rf_data_i (rt_rf),
        .exmem_wen_i  (em_wen),
        .exmem_dst_i  (em_dst),
        .exmem_res_i  (em_res),
        .memwb_wen_i  (mw_wen),
        .memwb_dst_i  (mw_dst),
        .memwb_res_i  (mw_res),
        .fwd_a_sel_o  (sel_a),
        .fwd_b_sel_o  (sel_b),
        .opnd_a_o     (op_a),
        .opnd_b_o     (op_b)
    );

    // Reference: a pending write is visible if enabled, non-zero and equal;
    // the younger stage is consulted first.
    function automatic logic [1:0] ref_sel(input logic [4:0] src);
        if (em_wen && em_dst == src && src != 0) return 2'b10;
        if (mw_wen && mw_dst == src && src != 0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b10) return em_res;
        if (s == 2'b01) return mw_res;
        return rf;
    endfunction

    function automatic string tag_of(input logic [1:0] s, input logic [4:0] src);
        if (s == 2'b10) return (mw_wen && mw_dst == src) ? "R4" : "R1";
        if (s == 2'b01) return "R3";
        if (src == 0) return "R5";
        return "R7";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare both operands against the model at the falling edge.
    task automatic compare(input string req_a, input string req_b);
        logic [1:0] ea, eb;
        @(negedge clk);
        ea = ref_sel(rs);
        eb = ref_sel(rt);
        check(req_a, "sel_a", {30'd0, sel_a}, {30'd0, ea});
        check(req_a, "op_a", op_a, ref_val(ea, rs_rf));
        check(req_b, "sel_b", {30'd0, sel_b}, {30'd0, eb});
        check(req_b, "op_b", op_b, ref_val(eb, rt_rf));
        check("R8", "sel_a not 11", {31'd0, sel_a == 2'b11}, 32'd0);
    endtask

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic ew, input logic [4:0] ed,
                         input logic mw, input logic [4:0] md);
        @(posedge clk);
        rs = a; rt = b; em_wen = ew; em_dst = ed; mw_wen = mw; mw_dst = md;
        rs_rf = 32'hA000_0000 | {27'd0, a};
        rt_rf = 32'hB000_0000 | {27'd0, b};
        em_res = $urandom; mw_res = $urandom;
    endtask

    initial begin
        rs = 0; rt = 0; em_wen = 0; em_dst = 0; mw_wen = 0; mw_dst = 0;
        rs_rf = 32'h1111_1111; rt_rf = 32'h2222_2222;
        em_res = 32'h3333_3333; mw_res = 32'h4444_4444;
        repeat (3) @(posedge clk);
        // Reset state: nothing pending, operands come from the register file (R7).
        @(negedge clk);
        check("R7", "reset sel_a", {30'd0, sel_a}, 32'd0);
        check("R7", "reset op_a", op_a, 32'h1111_1111);
        check("R7", "reset op_b", op_b, 32'h2222_2222);
        rst_n = 1'b1;

        drive(5'd3, 5'd4, 1, 5'd3, 0, 5'd0);  compare("R1", "R7");
        drive(5'd4, 5'd3, 1, 5'd3, 0, 5'd0);  compare("R7", "R2");
        drive(5'd7, 5'd9, 1, 5'd7, 1, 5'd9);  compare("R1", "R2");
        drive(5'd6, 5'd1, 0, 5'd0, 1, 5'd6);  compare("R3", "R7");
        drive(5'd8, 5'd8, 1, 5'd8, 1, 5'd8);  compare("R4", "R4");
        drive(5'd0, 5'd0, 1, 5'd0, 1, 5'd0);  compare("R5", "R5");
        drive(5'd0, 5'd2, 1, 5'd0, 1, 5'd2);  compare("R5", "R3");
        drive(5'd5, 5'd5, 0, 5'd5, 0, 5'd5);  compare("R6", "R6");
        drive(5'd5, 5'd12, 0, 5'd5, 1, 5'd5); compare("R3", "R7");
        drive(5'd31, 5'd30, 1, 5'd31, 1, 5'd30); compare("R1", "R3");
        drive(5'd10, 5'd11, 1, 5'd12, 1, 5'd13); compare("R7", "R7");

        for (int i = 0; i < N_RANDOM; i++) begin
            drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)));
            @(negedge clk);
            begin
                logic [1:0] ea, eb;
                ea = ref_sel(rs);
                eb = ref_sel(rt);
                check(tag_of(ea, rs), "rand sel_a", {30'd0, sel_a}, {30'd0, ea});
                check("R8", "rand op_a", op_a, ref_val(ea, rs_rf));
                check(tag_of(eb, rt), "rand sel_b", {30'd0, sel_b}, {30'd0, eb});
                check("R8", "rand op_b", op_b, ref_val(eb, rt_rf));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule